// File: doc/BRIEF.md
# Credit-Gated Flash Command Sequencer

This block sits between a byte-wide command queue and the arbiter of a shared flash bus. It takes command bytes from the head of the queue one at a time. Software groups them into sequences that open with a bus-acquire byte and close with a bus-release byte. Before a sequence may start, the block needs a credit from a signed doorbell counter. Software raises the counter by writing a signed amount. The block spends one credit each time it takes a bus-acquire byte, and it waits on that byte while the counter is zero or negative.

When an acquire is taken, the block raises a bus request and waits for the grant before it takes any further byte. The request stays up until the matching release byte is taken. An execution-disable input halts fetching at the next command boundary. An idle output tells software when no sequence is open and the queue is empty. Bytes other than acquire, release and the idle opcode go out unchanged on a one-cycle strobe for a downstream engine to handle. A programmable watchdog flags a grant that never arrives. An illegal controller state raises a sticky bad-state flag.

Top module: `cseq_exec`

## Requirements
- R1: After a synchronous active-low reset, the doorbell count is 0, the bus request is low, the stall, watchdog and bad-state flags are low, and idle is high while the queue is empty.
- R2: A doorbell write adds its 8-bit two's-complement data to the count. The count wraps modulo 256, so 127 + 1 reads back as 8'h80. The count is readable at all times on `db_count`.
- R3: Taking a bus-acquire byte (8'h5A) while the count is positive pops it, lowers the count by 1 and raises `bus_req` on the next cycle. `bus_req` stays high until a bus-release byte (8'hA5) is popped.
- R4: A bus-acquire byte at the head while the count is zero or negative is not popped. `seq_stalled` goes high, and `bus_req` and the count stay unchanged.
- R5: A stalled acquire stays stalled through doorbell writes that leave the count at or below zero. It is popped on the cycle after a write makes the count positive.
- R6: When a doorbell write and an acquire pop fall on the same cycle, both take effect: the new count is the old count plus the signed data minus 1.
- R7: After an acquire is popped, no further byte is popped until `bus_gnt` has been seen high.
- R8: While `exec_dis` is 1, no byte is popped from the fetch state, even if the queue holds bytes. When it clears, fetching resumes if the queue is not empty.
- R9: `seq_idle` is 1 only when no sequence is open (no acquire without a release), no acquire is waiting, and the queue is empty.
- R10: If the block waits for a grant for `wdog_limit` cycles without a byte being popped, `wdog_err` is set and stays set until reset. A grant that arrives earlier leaves it clear.
- R11: Any other byte is popped one per cycle and shown on `op_byte` with a one-cycle `op_valid`. The idle opcode (8'h00) is popped without raising `op_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command queue is not empty |
| cmd_byte | input | 8 | Byte at the head of the queue |
| cmd_pop | output | 1 | Removes the head byte at this clock edge |
| db_wr | input | 1 | Doorbell write strobe |
| db_wdata | input | 8 | Signed amount added to the count |
| db_count | output | 8 | Current signed doorbell count |
| exec_dis | input | 1 | Stop fetching at the next command boundary |
| bus_req | output | 1 | Flash bus request |
| bus_gnt | input | 1 | Flash bus grant |
| wdog_limit | input | 16 | Grant-wait cycles before the watchdog trips; 0 disables it |
| op_valid | output | 1 | Pass-through command strobe |
| op_byte | output | 8 | Pass-through command byte |
| seq_stalled | output | 1 | Acquire waiting for doorbell credit |
| seq_idle | output | 1 | No open sequence and queue empty |
| wdog_err | output | 1 | Sticky watchdog expiry flag |
| sm_bad | output | 1 | Sticky illegal-state flag |

## Verification
The hardest case to reach from the ports is the single cycle in which a doorbell write and a credit spend land on the same edge. The bench first loads credit while `exec_disable` holds an acquire at the head of the queue. It then releases the disable and writes the doorbell in the same cycle, so the pop and the increment meet. The stall-resume path is reached by writing a negative amount first, which keeps the stall, and then a positive one. The bench then checks the exact cycle on which the pop happens.

// File: rtl/cseq_pkg.sv
// Package: shared opcodes and controller state encoding for the command sequencer.
// Assumes 8-bit command bytes; the state field is 2 bits wide so one code is unused.
package cseq_pkg;
    localparam int CMD_W = 8;
    localparam logic [CMD_W-1:0] OP_ACQ  = 8'h5A;
    localparam logic [CMD_W-1:0] OP_REL  = 8'hA5;
    localparam logic [CMD_W-1:0] OP_IDLE = 8'h00;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_STALL = 2'd1,
        ST_GRANT = 2'd2
    } seq_state_t;
endpackage

// File: rtl/cseq_credit.sv
// Module: signed doorbell credit counter.
// Software adds a signed delta and hardware subtracts one per spent credit.
// Both may happen in one cycle. Wraps modulo 2**CNT_W.
module cseq_credit #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_wr,
    input  logic [CNT_W-1:0] sw_delta,
    input  logic             hw_take,
    output logic [CNT_W-1:0] count,
    output logic             has_credit
);
    logic [CNT_W-1:0] add_term;
    logic [CNT_W-1:0] sub_term;

    // Select the terms that apply this cycle.
    always_comb begin
        add_term = sw_wr ? sw_delta : '0;
        sub_term = hw_take ? CNT_W'(1) : '0;
    end

    // Update the count with both terms at once.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count + add_term - sub_term;
    end

    // A credit exists when the signed count is strictly positive.
    assign has_credit = ($signed(count) > 0);
endmodule

// File: rtl/cseq_wdog.sv
// Module: grant-wait watchdog.
// Reloads on every popped command and counts the cycles spent waiting while active.
// The sticky flag sets when the count reaches the programmed limit; a limit of 0 disables it.
module cseq_wdog #(
    parameter int WD_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reload,
    input  logic            active,
    input  logic [WD_W-1:0] limit,
    output logic            expired
);
    localparam logic [WD_W-1:0] WD_MAX = '1;
    logic [WD_W-1:0] wcnt;

    // Count the waiting cycles, saturating at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n || reload)             wcnt <= '0;
        else if (active && wcnt != WD_MAX) wcnt <= wcnt + 1'b1;
    end

    // Latch expiry until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            expired <= 1'b0;
        else if (active && !reload && limit != '0 && wcnt >= limit)
            expired <= 1'b1;
    end

    // R10: once set the flag holds
    p_wdog_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> expired);
endmodule

// File: rtl/cseq_fsm.sv
// Module: command fetch controller.
// Takes bytes from the queue head, gates acquires on credit, waits for the grant,
// and tracks the open sequence. Assumes the queue only changes its head through cmd_pop.
module cseq_fsm
    import cseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_byte,
    input  logic             exec_dis,
    input  logic             has_credit,
    input  logic             bus_gnt,
    output logic             cmd_pop,
    output logic             take_credit,
    output logic             granting,
    output logic             bus_req,
    output logic             stalled,
    output logic             idle,
    output logic             op_valid,
    output logic [CMD_W-1:0] op_byte,
    output logic             sm_bad
);
    seq_state_t state, state_nx;
    logic       bad_hit;
    logic       rel_pop;

    // Decide next state and the pop for this cycle.
    always_comb begin
        state_nx    = state;
        cmd_pop     = 1'b0;
        take_credit = 1'b0;
        rel_pop     = 1'b0;
        op_valid    = 1'b0;
        bad_hit     = 1'b0;
        case (state)
            ST_FETCH: begin
                if (cmd_valid && !exec_dis) begin
                    if (cmd_byte == OP_ACQ) begin
                        if (has_credit) begin
                            cmd_pop     = 1'b1;
                            take_credit = 1'b1;
                            state_nx    = ST_GRANT;
                        end else begin
                            state_nx    = ST_STALL;
                        end
                    end else begin
                        cmd_pop  = 1'b1;
                        rel_pop  = (cmd_byte == OP_REL);
                        op_valid = (cmd_byte != OP_REL) && (cmd_byte != OP_IDLE);
                    end
                end
            end
            ST_STALL: begin
                if (has_credit) begin
                    cmd_pop     = 1'b1;
                    take_credit = 1'b1;
                    state_nx    = ST_GRANT;
                end
            end
            ST_GRANT: begin
                if (bus_gnt) state_nx = ST_FETCH;
            end
            default: begin
                bad_hit  = 1'b1;
                state_nx = ST_FETCH;
            end
        endcase
    end

    // Advance the controller state.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FETCH;
        else        state <= state_nx;
    end

    // Hold the bus request from acquire pop to release pop.
    always_ff @(posedge clk) begin
        if (!rst_n)           bus_req <= 1'b0;
        else if (take_credit) bus_req <= 1'b1;
        else if (rel_pop)     bus_req <= 1'b0;
    end

    // Latch any visit to the unused state code.
    always_ff @(posedge clk) begin
        if (!rst_n)       sm_bad <= 1'b0;
        else if (bad_hit) sm_bad <= 1'b1;
    end

    assign op_byte  = cmd_byte;
    assign stalled  = (state == ST_STALL);
    assign granting = (state == ST_GRANT);
    assign idle     = (state == ST_FETCH) && !bus_req && !cmd_valid;

    // R7: nothing is popped while the grant is outstanding
    p_hold_for_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (granting && !bus_gnt) |=> !cmd_pop);
    // R3: request stays up until a release byte leaves the queue
    p_req_until_rel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !(cmd_pop && cmd_byte == OP_REL)) |=> bus_req);
    // R8: disable blocks fetching from the fetch state
    p_dis_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_dis && state == ST_FETCH) |-> !cmd_pop);
endmodule

// File: rtl/cseq_exec.sv
// Module: top of the credit-gated command sequencer.
// Joins the credit counter, the fetch controller and the grant watchdog.
// Assumes the queue presents its head combinationally and pops on the clock edge.
module cseq_exec
    import cseq_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int WD_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_byte,
    output logic             cmd_pop,
    input  logic             db_wr,
    input  logic [CNT_W-1:0] db_wdata,
    output logic [CNT_W-1:0] db_count,
    input  logic             exec_dis,
    output logic             bus_req,
    input  logic             bus_gnt,
    input  logic [WD_W-1:0]  wdog_limit,
    output logic             op_valid,
    output logic [CMD_W-1:0] op_byte,
    output logic             seq_stalled,
    output logic             seq_idle,
    output logic             wdog_err,
    output logic             sm_bad
);
    logic has_credit;
    logic take_credit;
    logic granting;

    cseq_credit #(.CNT_W(CNT_W)) u_credit (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_wr      (db_wr),
        .sw_delta   (db_wdata),
        .hw_take    (take_credit),
        .count      (db_count),
        .has_credit (has_credit)
    );

    cseq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_byte    (cmd_byte),
        .exec_dis    (exec_dis),
        .has_credit  (has_credit),
        .bus_gnt     (bus_gnt),
        .cmd_pop     (cmd_pop),
        .take_credit (take_credit),
        .granting    (granting),
        .bus_req     (bus_req),
        .stalled     (seq_stalled),
        .idle        (seq_idle),
        .op_valid    (op_valid),
        .op_byte     (op_byte),
        .sm_bad      (sm_bad)
    );

    cseq_wdog #(.WD_W(WD_W)) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .reload  (cmd_pop),
        .active  (granting && !bus_gnt),
        .limit   (wdog_limit),
        .expired (wdog_err)
    );

    // R4: a stalled acquire without credit is never popped
    p_stall_no_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_stalled && $signed(db_count) <= 0) |-> !cmd_pop);
    // R3: acquire pop without a write lowers the count by one
    p_acq_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pop && cmd_byte == OP_ACQ && !db_wr) |=>
        (db_count == CNT_W'($past(db_count) - 1'b1)));
    // R6: write and spend on the same edge both apply
    p_sum_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pop && cmd_byte == OP_ACQ && db_wr) |=>
        (db_count == CNT_W'($past(db_count) + $past(db_wdata) - 1'b1)));
    // R9: idle never reported with bytes waiting
    p_idle_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_idle |-> (!cmd_valid && !bus_req));
endmodule

// File: tb/cseq_exec_test.sv
module cseq_exec_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid;
    logic [7:0]  cmd_byte;
    logic        cmd_pop;
    logic        db_wr = 1'b0;
    logic [7:0]  db_wdata = 8'h00;
    logic [7:0]  db_count;
    logic        exec_dis = 1'b0;
    logic        bus_req;
    logic        bus_gnt = 1'b0;
    logic [15:0] wdog_limit = 16'd4;
    logic        op_valid;
    logic [7:0]  op_byte;
    logic        seq_stalled, seq_idle, wdog_err, sm_bad;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    logic [7:0] qmem [0:63];
    logic [6:0] rd_ptr;
    logic [6:0] wr_ptr = '0;
    int         op_cnt;
    logic [7:0] last_op;

    always #2 clk = ~clk;

    assign cmd_valid = (rd_ptr != wr_ptr);
    assign cmd_byte  = qmem[rd_ptr[5:0]];

    cseq_exec uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .cmd_pop(cmd_pop), .db_wr(db_wr), .db_wdata(db_wdata), .db_count(db_count),
        .exec_dis(exec_dis), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .wdog_limit(wdog_limit), .op_valid(op_valid), .op_byte(op_byte),
        .seq_stalled(seq_stalled), .seq_idle(seq_idle), .wdog_err(wdog_err),
        .sm_bad(sm_bad)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            op_cnt <= 0;
            last_op <= 8'h00;
        end else begin
            if (cmd_pop) rd_ptr <= rd_ptr + 1'b1;
            if (op_valid) begin
                op_cnt  <= op_cnt + 1;
                last_op <= op_byte;
            end
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic push(input logic [7:0] b);
        qmem[wr_ptr[5:0]] = b;
        wr_ptr = wr_ptr + 1'b1;
    endtask

    task automatic ring(input logic [7:0] d);
        db_wr = 1'b1; db_wdata = d;
        @(negedge clk);
        db_wr = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; exec_dis = 1'b0; bus_gnt = 1'b0; db_wr = 1'b0;
        wr_ptr = '0;
        cycles(2);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 count", db_count, 0);
        check("R1 bus_req", bus_req, 0);
        check("R1 idle", seq_idle, 1);
        check("R1 stalled", seq_stalled, 0);
        check("R1 wdog", wdog_err, 0);
        check("R1 sm_bad", sm_bad, 0);
    endtask

    task automatic t_doorbell();
        do_reset();
        ring(8'd3);
        check("R2 add 3", db_count, 3);
        ring(8'hFE);
        check("R2 add -2", db_count, 1);
        ring(8'h7E);
        check("R2 reach 127", db_count, 8'h7F);
        ring(8'h01);
        check("R2 wrap", db_count, 8'h80);
    endtask

    task automatic t_acquire();
        do_reset();
        ring(8'd2);
        push(8'h5A); push(8'h33); push(8'hA5);
        @(negedge clk);
        check("R3 count dec", db_count, 1);
        check("R3 bus_req up", bus_req, 1);
        cycles(3);
        check("R7 no pop before grant", int'(rd_ptr), 1);
        check("R7 no op before grant", op_cnt, 0);
        check("R9 not idle", seq_idle, 0);
        bus_gnt = 1'b1;
        @(negedge clk);
        bus_gnt = 1'b0;
        @(negedge clk);
        check("R3 req held mid-seq", bus_req, 1);
        cycles(2);
        check("R3 req dropped", bus_req, 0);
        check("R11 op count", op_cnt, 1);
        check("R11 op byte", last_op, 8'h33);
        check("R9 idle after release", seq_idle, 1);
    endtask

    task automatic t_stall();
        do_reset();
        push(8'h5A); push(8'hA5);
        cycles(3);
        check("R4 stalled", seq_stalled, 1);
        check("R4 no req", bus_req, 0);
        check("R4 count kept", db_count, 0);
        check("R4 not popped", int'(rd_ptr), 0);
        check("R9 stalled not idle", seq_idle, 0);
        ring(8'hFF);
        cycles(2);
        check("R5 negative stays stalled", seq_stalled, 1);
        check("R5 count -1", db_count, 8'hFF);
        ring(8'd2);
        check("R5 count now 1", db_count, 1);
        check("R5 not yet popped", bus_req, 0);
        @(negedge clk);
        check("R5 popped", bus_req, 1);
        check("R5 count spent", db_count, 0);
        bus_gnt = 1'b1;
        cycles(2);
        bus_gnt = 1'b0;
        check("R3 release", bus_req, 0);
    endtask

    task automatic t_simul();
        do_reset();
        ring(8'd2);
        exec_dis = 1'b1;
        push(8'h5A);
        cycles(2);
        check("R8 held by disable", bus_req, 0);
        check("R8 count untouched", db_count, 2);
        exec_dis = 1'b0;
        db_wr = 1'b1; db_wdata = 8'd5;
        @(negedge clk);
        db_wr = 1'b0;
        check("R6 count plus data minus one", db_count, 6);
        check("R6 acquire taken", bus_req, 1);
    endtask

    task automatic t_disable();
        do_reset();
        bus_gnt = 1'b1;
        exec_dis = 1'b1;
        push(8'h11); push(8'h22);
        cycles(3);
        check("R8 no ops while disabled", op_cnt, 0);
        check("R9 queue nonempty not idle", seq_idle, 0);
        exec_dis = 1'b0;
        cycles(2);
        check("R8 resumed", op_cnt, 2);
        check("R11 last op", last_op, 8'h22);
        push(8'h00);
        cycles(2);
        check("R11 idle opcode no strobe", op_cnt, 2);
        check("R11 idle opcode consumed", int'(rd_ptr), 3);
        check("R9 idle", seq_idle, 1);
        bus_gnt = 1'b0;
    endtask

    task automatic t_wdog();
        do_reset();
        wdog_limit = 16'd4;
        ring(8'd2);
        push(8'h5A); push(8'hA5); push(8'h5A);
        cycles(3);
        check("R10 early grant no trip", wdog_err, 0);
        bus_gnt = 1'b1;
        @(negedge clk);
        bus_gnt = 1'b0;
        cycles(3);
        check("R10 second acquire held", bus_req, 1);
        check("R10 still clear", wdog_err, 0);
        cycles(10);
        check("R10 expired", wdog_err, 1);
        bus_gnt = 1'b1;
        cycles(2);
        bus_gnt = 1'b0;
        check("R10 sticky", wdog_err, 1);
    endtask

    initial begin
        t_reset();
        t_doorbell();
        t_acquire();
        t_stall();
        t_simul();
        t_disable();
        t_wdog();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule